// File: doc/BRIEF.md
# Logic Self-Test Run Sequencer

This block drives a logic built-in self-test run that is split into numbered test intervals. Software programs a control word (interval count, restart-or-resume choice, serial or parallel treatment of a primary and a redundant element, test clock divider) and a timeout budget in bus-clock cycles. It then arms the run by writing a key. The sequencer issues a divided test clock enable and tells the external test engine which interval and which element(s) are under test. It collects per-phase done/fail handshakes and stops on completion, on the first failure or on timeout.

Every run ends with a one-cycle reset request to the tested core. At that moment the result is folded into sticky status bits that the core reset does not touch. The interval pointer is kept between runs, so a long test can be split into short slices that each resume where the last one stopped. The test clock is a single-domain enable pulse, not a derived clock.

Register map (word addresses on `bus_addr`): 0 = control (`[15:0]` interval count, `[16]` restart bit, `[17]` parallel bit, `[20:18]` divider), 1 = timeout preload, 2 = arm key `[3:0]`, 3 = status (`[0]` done, `[1]` fail, `[2]` timeout), 4 = interval pointer (read only). Other addresses read as zero.

Top module: `lbist_ctrl`

## Requirements
- R1: After reset, status reads 0, the key field reads 4'h5, control, timeout and pointer read 0, and `test_active`, `tck_en` and `core_rst_req` are low.
- R2: A run starts on the clock after the key field holds 4'hA while idle. Writing any other value to address 2 stores it and leaves the block idle.
- R3: A run executes min(count, MAX_INTERVALS) intervals. A count of 0 ends the run at once without any active cycle, setting done only.
- R4: During a run `tck_en` pulses on active cycles div+1, 2(div+1), and so on, where div is control bits `[20:18]`. It never pulses outside a run.
- R5: With the parallel bit set, each interval is one phase with `elem_sel` = 2'b11. With it clear, each interval is two phases, 2'b01 then 2'b10. `elem_sel` is 0 when idle. A phase completes on a `tck_en` cycle with `ivl_done` high.
- R6: The pointer is set to 0 at start when the restart bit is 1 and otherwise kept. It advances by one per completed interval, wrapping from MAX_INTERVALS-1 to 0. The restart bit reads 0 after every run.
- R7: With timeout preload P, a run still active on its active cycle P+1 ends with status done and timeout set. On that cycle, expiry wins over a completion.
- R8: A phase completing with `ivl_fail` high ends the run with done and fail set. The pointer stays on the failing interval.
- R9: Every run end gives exactly one cycle of `core_rst_req`, in the cycle after the last active cycle, and the key field then reads 4'h5.
- R10: Status bits are sticky and are cleared only by writing 1 to the same bit position of address 3.
- R11: Writes to addresses 0, 1 and 2 during a run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus/system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address (read and write) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ivl_done | input | 1 | Test engine: current phase finished (sampled on `tck_en`) |
| ivl_fail | input | 1 | Test engine: current phase failed (with `ivl_done`) |
| tck_en | output | 1 | Divided test clock enable |
| test_active | output | 1 | Run in progress |
| elem_sel | output | 2 | Elements under test: bit 0 primary, bit 1 redundant |
| cur_ivl | output | IW | Current interval pointer |
| core_rst_req | output | 1 | One-cycle reset request to the tested core |

## Verification
A wrong phase counter or pointer shows as a wrong pointer readback and a wrong `elem_sel` sequence within the same run. A miscounted divider or timer shifts the measured active length and the `tck_en` count by at least one cycle, and the bench compares both against arithmetic expectations for every divider, mode, count and boundary preload. A stuck end state shows at once as a missing or extended `core_rst_req` pulse and a key field that does not return to the disabled code.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_END  = 2'd2
  } lb_state_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TMO  = 3'd1;
  localparam logic [2:0] A_ARM  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_PTR  = 3'd4;

  localparam logic [3:0] KEY_GO  = 4'hA;
  localparam logic [3:0] KEY_OFF = 4'h5;

  localparam int DIV_W = 3;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             par;
    logic             restart;
    logic [15:0]      count;
  } lb_cfg_t;

endpackage

// File: rtl/lbist_regs.sv
module lbist_regs
  import lbist_pkg::*;
#(
  parameter int IW    = 3,
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic             end_now,
  input  logic             end_fail,
  input  logic             end_tmo,
  input  logic [IW-1:0]    ptr,
  output lb_cfg_t          cfg,
  output logic [TMO_W-1:0] tmo_pre,
  output logic             armed
);

  localparam int CFG_W = $bits(lb_cfg_t);

  lb_cfg_t          cfg_q, cfg_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic [3:0]       key_q, key_d;
  logic [2:0]       stat_q, stat_d;
  logic             unused_hi;

  assign unused_hi = ^wdata[31:CFG_W];

  always_comb begin
    cfg_d  = cfg_q;
    tmo_d  = tmo_q;
    key_d  = key_q;
    stat_d = stat_q;
    if (wr && !busy) begin
      case (addr)
        A_CTRL:  cfg_d = lb_cfg_t'(wdata[CFG_W-1:0]);
        A_TMO:   tmo_d = wdata[TMO_W-1:0];
        A_ARM:   key_d = wdata[3:0];
        default: ;
      endcase
    end
    if (wr && (addr == A_STAT)) begin
      stat_d = stat_q & ~wdata[2:0];
    end
    if (end_now) begin
      stat_d        = stat_d | {end_tmo, end_fail, 1'b1};
      cfg_d.restart = 1'b0;
      key_d         = KEY_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      tmo_q  <= '0;
      key_q  <= KEY_OFF;
      stat_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      tmo_q  <= tmo_d;
      key_q  <= key_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = 32'(cfg_q);
      A_TMO:   rdata = 32'(tmo_q);
      A_ARM:   rdata = {28'd0, key_q};
      A_STAT:  rdata = {29'd0, stat_q};
      A_PTR:   rdata = 32'(ptr);
      default: rdata = '0;
    endcase
  end

  assign cfg     = cfg_q;
  assign tmo_pre = tmo_q;
  assign armed   = (key_q == KEY_GO);

endmodule

// File: rtl/lbist_clkdiv.sv
module lbist_clkdiv
  import lbist_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lbist_timer.sv
module lbist_timer #(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [TMO_W-1:0] preload,
  output logic             expired
);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expired = run && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = preload;
    end else if (run && !at_zero) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lbist_fsm.sv
module lbist_fsm
  import lbist_pkg::*;
#(
  parameter int MAX_INTERVALS = 8,
  parameter int IW            = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic [15:0]   count,
  input  logic          restart,
  input  logic          par,
  input  logic          tick,
  input  logic          expired,
  input  logic          ivl_done,
  input  logic          ivl_fail,
  output logic          load,
  output logic          run,
  output logic          busy,
  output logic          end_now,
  output logic          end_fail,
  output logic          end_tmo,
  output logic [1:0]    elem_sel,
  output logic [IW-1:0] ptr
);

  localparam logic [15:0]   MAX_CNT = 16'(MAX_INTERVALS);
  localparam logic [IW-1:0] PTR_TOP = IW'(MAX_INTERVALS - 1);

  lb_state_e     st_q, st_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic [15:0]   rem_q, rem_d;
  logic          ph_q, ph_d;
  logic          fail_q, fail_d;
  logic          tmo_q, tmo_d;
  logic [15:0]   eff_cnt;
  logic [IW-1:0] ptr_inc;

  assign eff_cnt = (count > MAX_CNT) ? MAX_CNT : count;
  assign ptr_inc = (ptr_q == PTR_TOP) ? '0 : ptr_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    rem_d  = rem_q;
    ph_d   = ph_q;
    fail_d = fail_q;
    tmo_d  = tmo_q;
    load   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (armed) begin
          fail_d = 1'b0;
          tmo_d  = 1'b0;
          if (eff_cnt == '0) begin
            st_d = ST_END;
          end else begin
            load  = 1'b1;
            st_d  = ST_RUN;
            rem_d = eff_cnt;
            ph_d  = 1'b0;
            if (restart) begin
              ptr_d = '0;
            end
          end
        end
      end
      ST_RUN: begin
        if (expired) begin
          tmo_d = 1'b1;
          st_d  = ST_END;
        end else if (tick && ivl_done) begin
          if (ivl_fail) begin
            fail_d = 1'b1;
            st_d   = ST_END;
          end else if (!par && !ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d  = 1'b0;
            ptr_d = ptr_inc;
            rem_d = rem_q - 1'b1;
            if (rem_q == 16'd1) begin
              st_d = ST_END;
            end
          end
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      rem_q  <= '0;
      ph_q   <= 1'b0;
      fail_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      rem_q  <= rem_d;
      ph_q   <= ph_d;
      fail_q <= fail_d;
      tmo_q  <= tmo_d;
    end
  end

  always_comb begin
    if (st_q != ST_RUN) begin
      elem_sel = 2'b00;
    end else if (par) begin
      elem_sel = 2'b11;
    end else begin
      elem_sel = ph_q ? 2'b10 : 2'b01;
    end
  end

  assign run      = (st_q == ST_RUN);
  assign busy     = (st_q != ST_IDLE);
  assign end_now  = (st_q == ST_END);
  assign end_fail = fail_q;
  assign end_tmo  = tmo_q;
  assign ptr      = ptr_q;

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int MAX_INTERVALS = 8,
  parameter int TMO_W         = 32,
  localparam int IW           = (MAX_INTERVALS > 1) ? $clog2(MAX_INTERVALS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ivl_done,
  input  logic          ivl_fail,
  output logic          tck_en,
  output logic          test_active,
  output logic [1:0]    elem_sel,
  output logic [IW-1:0] cur_ivl,
  output logic          core_rst_req
);

  logic [1:0]       rsync_q;
  logic             srst_n;
  lb_cfg_t          cfg;
  logic [TMO_W-1:0] tmo_pre;
  logic             armed, load, run, busy;
  logic             end_now, end_fail, end_tmo;
  logic             tick, expired;
  logic [IW-1:0]    ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign srst_n = rsync_q[1];

  lbist_regs #(.IW(IW), .TMO_W(TMO_W)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .busy     (busy),
    .end_now  (end_now),
    .end_fail (end_fail),
    .end_tmo  (end_tmo),
    .ptr      (ptr),
    .cfg      (cfg),
    .tmo_pre  (tmo_pre),
    .armed    (armed)
  );

  lbist_clkdiv u_div (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (load),
    .run   (run),
    .div   (cfg.div),
    .tick  (tick)
  );

  lbist_timer #(.TMO_W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (load),
    .run     (run),
    .preload (tmo_pre),
    .expired (expired)
  );

  lbist_fsm #(.MAX_INTERVALS(MAX_INTERVALS), .IW(IW)) u_fsm (
    .clk      (clk),
    .rst_n    (srst_n),
    .armed    (armed),
    .count    (cfg.count),
    .restart  (cfg.restart),
    .par      (cfg.par),
    .tick     (tick),
    .expired  (expired),
    .ivl_done (ivl_done),
    .ivl_fail (ivl_fail),
    .load     (load),
    .run      (run),
    .busy     (busy),
    .end_now  (end_now),
    .end_fail (end_fail),
    .end_tmo  (end_tmo),
    .elem_sel (elem_sel),
    .ptr      (ptr)
  );

  assign tck_en       = tick;
  assign test_active  = run;
  assign cur_ivl      = ptr;
  assign core_rst_req = end_now;

endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk #(
  parameter int MAX_INTERVALS = 8,
  parameter int IW            = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tck_en,
  input logic          test_active,
  input logic [1:0]    elem_sel,
  input logic [IW-1:0] cur_ivl,
  input logic          core_rst_req
);

  assert_tick_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tck_en |-> test_active);

  assert_idle_no_elem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !test_active |-> (elem_sel == 2'b00));

  assert_run_has_elem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |-> ($countones(elem_sel) >= 1));

  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ivl <= IW'(MAX_INTERVALS - 1));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(test_active) && (cur_ivl != $past(cur_ivl))) |->
      (cur_ivl == (($past(cur_ivl) == IW'(MAX_INTERVALS - 1)) ? '0 : $past(cur_ivl) + 1'b1)));

  assert_end_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_active) |-> core_rst_req);

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_req |=> !core_rst_req);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_req |-> !test_active);

endmodule

bind lbist_ctrl lbist_ctrl_chk #(.MAX_INTERVALS(MAX_INTERVALS), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tck_en       (tck_en),
  .test_active  (test_active),
  .elem_sel     (elem_sel),
  .cur_ivl      (cur_ivl),
  .core_rst_req (core_rst_req)
);

// File: tb/lbist_ctrl_test.sv
module lbist_ctrl_test;

  localparam int MAXI = 8;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ivl_done;
  logic        ivl_fail;
  logic        tck_en;
  logic        test_active;
  logic [1:0]  elem_sel;
  logic [2:0]  cur_ivl;
  logic        core_rst_req;

  logic        fail_en;
  logic [2:0]  fail_ivl;

  int checks;
  int errors;
  int model_ptr;
  int cnt_list [5] = '{0, 1, 3, 8, 11};

  lbist_ctrl #(.MAX_INTERVALS(MAXI), .TMO_W(32)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ivl_done     (ivl_done),
    .ivl_fail     (ivl_fail),
    .tck_en       (tck_en),
    .test_active  (test_active),
    .elem_sel     (elem_sel),
    .cur_ivl      (cur_ivl),
    .core_rst_req (core_rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign ivl_done = 1'b1;
  assign ivl_fail = fail_en && (cur_ivl == fail_ivl);

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_run(input int count, input bit restart, input bit par, input int div,
                        input int pre, input int fail_f, input bit mid);
    int eff, ppi, k, c, cf, start, act_e, tick_e, ptr_e, st_e;
    int active, ticks, pulses, elem_bad;
    bit midded, done_loop;
    string tg;
    logic [31:0] ctrl_w, v;
    eff   = (count > MAXI) ? MAXI : count;
    ppi   = par ? 1 : 2;
    k     = eff * ppi;
    c     = k * (div + 1);
    cf    = (fail_f * ppi + 1) * (div + 1);
    start = (eff > 0 && restart) ? 0 : model_ptr;
    if (eff == 0) begin
      act_e = 0; ptr_e = model_ptr; st_e = 1; tg = "R3";
    end else if (fail_f >= 0 && cf <= pre) begin
      act_e = cf; ptr_e = (start + fail_f) % MAXI; st_e = 3; tg = "R8";
    end else if (c > pre) begin
      act_e = pre + 1; ptr_e = (start + (pre / (div + 1)) / ppi) % MAXI; st_e = 5; tg = "R7";
    end else begin
      act_e = c; ptr_e = (start + eff) % MAXI; st_e = 1; tg = "R3";
    end
    tick_e   = act_e / (div + 1);
    fail_en  = (fail_f >= 0);
    fail_ivl = 3'((start + ((fail_f >= 0) ? fail_f : 0)) % MAXI);
    ctrl_w   = {11'd0, 3'(div), par, restart, 16'(count)};
    wr(3'd0, ctrl_w);
    wr(3'd1, 32'(pre));
    wr(3'd2, 32'h0000_000A);
    active = 0; ticks = 0; pulses = 0; elem_bad = 0; midded = 0; done_loop = 0;
    for (int g = 0; g < 4000 && !done_loop; g++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      if (test_active) begin
        active++;
        if (par ? (elem_sel != 2'b11) : !(elem_sel == 2'b01 || elem_sel == 2'b10)) elem_bad++;
      end
      if (tck_en) ticks++;
      if (core_rst_req) begin
        pulses++;
        done_loop = 1;
      end else if (mid && !midded && active == 3) begin
        midded    = 1;
        bus_wr    = 1'b1;
        bus_addr  = 3'd0;
        bus_wdata = {11'd0, 3'd0, ~par, 1'b1, 16'd1};
      end
    end
    if (!done_loop) chk("R9 run end not seen", 0, 1);
    chk({tg, " active cycles"}, active, act_e);
    chk("R4 tck_en count", ticks, tick_e);
    chk("R5 elem_sel pattern errors", elem_bad, 0);
    chk("R9 reset request pulses", pulses, 1);
    @(negedge clk);
    chk("R9 reset request released", core_rst_req, 0);
    rd(3'd3, v);
    chk({tg, " status"}, v, st_e);
    rd(3'd4, v);
    chk("R6 pointer", v, ptr_e);
    rd(3'd0, v);
    chk(mid ? "R11 control kept" : "R6 restart bit cleared", v, ctrl_w & ~32'h0001_0000);
    rd(3'd2, v);
    chk("R9 key disabled", v, 5);
    model_ptr = ptr_e;
    fail_en   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int act, pul, c, pre;
    checks = 0; errors = 0; model_ptr = 0;
    fail_en = 1'b0; fail_ivl = '0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk("R1 test_active", test_active, 0);
    chk("R1 tck_en", tck_en, 0);
    chk("R1 core_rst_req", core_rst_req, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 register reset value", v, (a == 2) ? 5 : 0);
    end

    // R2: wrong key stays idle
    wr(3'd0, 32'h0000_0003);
    wr(3'd1, 32'd1000);
    wr(3'd2, 32'h0000_0003);
    act = 0; pul = 0;
    repeat (20) begin
      @(negedge clk);
      if (test_active) act++;
      if (core_rst_req) pul++;
    end
    chk("R2 wrong key active cycles", act, 0);
    chk("R2 wrong key reset pulses", pul, 0);
    rd(3'd2, v);
    chk("R2 wrong key stored", v, 3);

    // sweep: divider, mode, count, preload boundary
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 2; p++) begin
        for (int ci = 0; ci < 5; ci++) begin
          for (int pi = 0; pi < 3; pi++) begin
            c   = ((cnt_list[ci] > MAXI) ? MAXI : cnt_list[ci]) * (p ? 1 : 2) * (d + 1);
            pre = (pi == 0) ? ((c > 0) ? c - 1 : 0) : ((pi == 1) ? c : 5000);
            do_run(cnt_list[ci], ((d + ci + pi) % 3) == 0, p[0], d, pre, -1, 1'b0);
            wr(3'd3, 32'h7);
            rd(3'd3, v);
            chk("R10 status cleared", v, 0);
          end
        end
      end
    end

    // R3: very large count clamps
    do_run(65535, 1'b1, 1'b1, 0, 5000, -1, 1'b0);
    wr(3'd3, 32'h7);

    // R8: failures, and timeout winning before a late failure (R7)
    do_run(5, 1'b1, 1'b0, 1, 1000, 2, 1'b0);
    // R10: partial write-one-to-clear
    wr(3'd3, 32'h1);
    rd(3'd3, v);
    chk("R10 only done cleared", v, 2);
    wr(3'd3, 32'h0);
    rd(3'd3, v);
    chk("R10 zero write keeps", v, 2);
    wr(3'd3, 32'h2);
    rd(3'd3, v);
    chk("R10 fail cleared", v, 0);
    do_run(4, 1'b0, 1'b1, 0, 1000, 0, 1'b0);
    wr(3'd3, 32'h7);
    do_run(5, 1'b1, 1'b0, 1, 5, 1, 1'b0);
    wr(3'd3, 32'h7);

    // R11: writes during a run are ignored
    do_run(6, 1'b0, 1'b0, 2, 5000, -1, 1'b1);
    wr(3'd3, 32'h7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule